// File: doc/BRIEF.md
# Job Ring Occupancy and Interrupt Controller

This block keeps the control-plane counts for one pair of descriptor rings: an input ring that software fills with jobs and a processing engine drains, and an output ring that the engine fills with results and software drains. Software reports new input jobs and retired output entries by writing counts into a 32-bit register port. The engine reports each job it takes (consume strobe) and each result it writes (produce strobe). From these the block derives the free input room, the number of full output slots and the head index of each ring.

Overflow writes are rejected whole and logged with a typed error code and the ring index at the time of the fault. Completion interrupts can be raised per result, or coalesced until a result count is reached or a timer runs out after the first pending result. A ring-reset command stops new work, waits until no job is in flight, then clears the counts and indices and reports that the halt is complete. Descriptor fetch and memory traffic are outside this block.

Top module: `jobring_occ_ctrl`

## Requirements
- R1: After reset every register reads zero (both sizes, room, full count, config, status, indices) and the interrupt output is low.
- R2: Register offsets are 0 input ring size, 1 output ring size, 2 jobs-added count (write) / free input room (read), 3 jobs-removed count (write) / full output slots (read), 4 config, 5 status, 6 command, 7 indices. Sizes and counts use bits 9:0. Room reads as input size minus queued jobs; an accepted add lowers room, an accepted produce raises the full count and an accepted remove lowers it.
- R3: An accepted consume advances the input read index and an accepted produce advances the output write index, each wrapping to 0 at its ring size; offset 7 reads the input read index in bits 9:0 and the output write index in bits 25:16. A consume is accepted only while input jobs are queued; a produce only while a job is in flight and the output ring is not full.
- R4: An add count above the free room leaves all counts unchanged, sets status bit 1 (error), writes 9 into status bits 11:8 and the input read index into status bits 29:16.
- R5: A remove count above the full count leaves all counts unchanged, sets status bit 1, writes 8 into bits 11:8 and the output write index into bits 29:16.
- R6: With coalescing off (config bit 1 = 0) every accepted produce sets status bit 0 (done) at the same clock edge.
- R7: The interrupt output equals (done or error) and not config bit 0 (mask).
- R8: While the error bit is set and config bit 2 (stop on error) is set, consume strobes are ignored.
- R9: Writing 1 to status bit 0 clears done, to bit 1 clears the error bit, type and index, and to bit 3 returns a completed halt to idle; a new event in the same cycle wins over the clear.
- R10: Writing 1 to command bit 0 sets status bits 3:2 to 01 (reads 0x4); while so, consumes and add/remove writes are ignored; once no job is in flight the queued count, full count and both indices clear and bits 3:2 become 10 (reads 0x8).
- R11: With coalescing on, done is set when pending results reach the count threshold in config bits 15:8; a threshold of 0 acts as 1.
- R12: With coalescing on and a nonzero timer threshold T in config bits 23:16, done is set T cycles after the first pending result was accepted if the count was not reached first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| consumeStb | input | 1 | Engine took one job from the input ring |
| produceStb | input | 1 | Engine wrote one result to the output ring |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 10-bit size fields and 8-bit thresholds but programs an input ring of 8 and an output ring of 4, so add and remove overflows, a full output ring and the output index wrap all occur within a few dozen writes. A count threshold of 3 and a timer of 5 cycles keep both coalescing triggers inside short windows, and a zero threshold checks the act-as-one rule during a reset drain that has exactly one job in flight.

// File: rtl/jrq_pkg.sv
package jrq_pkg;

  typedef struct packed {
    logic add;
    logic remove;
    logic consume;
    logic produce;
    logic clear;
  } ringStb_t;

  localparam logic [2:0] ADR_IN_SIZE  = 3'd0;
  localparam logic [2:0] ADR_OUT_SIZE = 3'd1;
  localparam logic [2:0] ADR_ADD      = 3'd2;
  localparam logic [2:0] ADR_REMOVE   = 3'd3;
  localparam logic [2:0] ADR_CONFIG   = 3'd4;
  localparam logic [2:0] ADR_STATUS   = 3'd5;
  localparam logic [2:0] ADR_COMMAND  = 3'd6;
  localparam logic [2:0] ADR_INDEX    = 3'd7;

  localparam logic [3:0] ERR_REMOVE_OVF = 4'd8;
  localparam logic [3:0] ERR_ADD_OVF    = 4'd9;

  localparam logic [1:0] HALT_IDLE = 2'b00;
  localparam logic [1:0] HALT_BUSY = 2'b01;
  localparam logic [1:0] HALT_DONE = 2'b10;

  localparam int ERR_IDX_W = 14;

endpackage

// File: rtl/jrq_counters.sv
module jrq_counters
  import jrq_pkg::*;
#(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStb_t          stb,
  input  logic [SIZE_W-1:0] cnt,
  input  logic [SIZE_W-1:0] inSize,
  input  logic [SIZE_W-1:0] outSize,
  output logic [SIZE_W-1:0] inQueued,
  output logic [SIZE_W-1:0] outFull,
  output logic [SIZE_W-1:0] inRdIdx,
  output logic [SIZE_W-1:0] outWrIdx,
  output logic [SIZE_W:0]   inFlight
);
  localparam int FL_W = SIZE_W + 1;

  function automatic logic [SIZE_W-1:0] nextIdx(input logic [SIZE_W-1:0] idx,
                                                 input logic [SIZE_W-1:0] size);
    logic [SIZE_W:0] inc;
    inc = {1'b0, idx} + FL_W'(1);
    return (inc >= {1'b0, size}) ? '0 : inc[SIZE_W-1:0];
  endfunction

  logic [SIZE_W-1:0] addAmt, remAmt;
  assign addAmt = stb.add    ? cnt : '0;
  assign remAmt = stb.remove ? cnt : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inQueued <= '0;
      outFull  <= '0;
      inRdIdx  <= '0;
      outWrIdx <= '0;
      inFlight <= '0;
    end else if (stb.clear) begin
      inQueued <= '0;
      outFull  <= '0;
      inRdIdx  <= '0;
      outWrIdx <= '0;
      inFlight <= '0;
    end else begin
      inQueued <= inQueued + addAmt - SIZE_W'(stb.consume);
      outFull  <= outFull + SIZE_W'(stb.produce) - remAmt;
      inFlight <= inFlight + FL_W'(stb.consume) - FL_W'(stb.produce);
      if (stb.consume) inRdIdx  <= nextIdx(inRdIdx, inSize);
      if (stb.produce) outWrIdx <= nextIdx(outWrIdx, outSize);
    end
  end
endmodule

// File: rtl/jrq_coalesce.sv
module jrq_coalesce #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             coalEn,
  input  logic             produceOk,
  input  logic [THR_W-1:0] cntThr,
  input  logic [THR_W-1:0] timThr,
  output logic             doneEvt
);
  localparam int EXT_W = THR_W + 1;

  logic [THR_W-1:0] pend, timer, effThr;
  logic [THR_W:0]   pendNext, timerNext;
  logic             cntHit, timHit;

  assign effThr    = (cntThr == '0) ? THR_W'(1) : cntThr;
  assign pendNext  = {1'b0, pend} + EXT_W'(produceOk);
  assign timerNext = {1'b0, timer} + EXT_W'(1);
  assign cntHit    = coalEn && (pendNext >= {1'b0, effThr});
  assign timHit    = coalEn && (pend != '0) && (timThr != '0) &&
                     (timerNext >= {1'b0, timThr});
  assign doneEvt   = coalEn ? (cntHit || timHit) : produceOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend  <= '0;
      timer <= '0;
    end else if (clear || !coalEn || doneEvt) begin
      pend  <= '0;
      timer <= '0;
    end else begin
      pend  <= pendNext[THR_W-1:0];
      timer <= (pend != '0) ? timerNext[THR_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/jrq_ctrl.sv
module jrq_ctrl
  import jrq_pkg::*;
#(
  parameter int SIZE_W = 10,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              consumeStb,
  input  logic              produceStb,
  input  logic [SIZE_W-1:0] inQueued,
  input  logic [SIZE_W-1:0] outFull,
  input  logic [SIZE_W:0]   inFlight,
  input  logic [SIZE_W-1:0] inRdIdx,
  input  logic [SIZE_W-1:0] outWrIdx,
  input  logic              doneEvt,
  output ringStb_t          stb,
  output logic [SIZE_W-1:0] cnt,
  output logic [SIZE_W-1:0] inSize,
  output logic [SIZE_W-1:0] outSize,
  output logic [SIZE_W-1:0] room,
  output logic              cfgMask,
  output logic              cfgCoalEn,
  output logic              cfgSoe,
  output logic [THR_W-1:0]  cntThr,
  output logic [THR_W-1:0]  timThr,
  output logic [1:0]        haltState,
  output logic              errFlag,
  output logic [3:0]        errType,
  output logic              doneFlag,
  output logic              irqOut,
  output logic [31:0]       regRdata
);
  logic [ERR_IDX_W-1:0] errIdx;
  logic halting, stopped;
  logic wrAdd, wrRem, wrStat, wrCfg, wrCmd;
  logic addOvf, remOvf;
  logic unusedHigh;

  assign unusedHigh = ^regWdata[31:24];

  assign cnt     = regWdata[SIZE_W-1:0];
  assign room    = (inQueued >= inSize) ? '0 : inSize - inQueued;
  assign halting = (haltState == HALT_BUSY);
  assign stopped = errFlag && cfgSoe;

  assign wrAdd  = regWe && (regAddr == ADR_ADD);
  assign wrRem  = regWe && (regAddr == ADR_REMOVE);
  assign wrStat = regWe && (regAddr == ADR_STATUS);
  assign wrCfg  = regWe && (regAddr == ADR_CONFIG);
  assign wrCmd  = regWe && (regAddr == ADR_COMMAND);

  assign addOvf = wrAdd && !halting && (cnt > room);
  assign remOvf = wrRem && !halting && (cnt > outFull);

  always_comb begin
    stb.add     = wrAdd && !halting && !addOvf;
    stb.remove  = wrRem && !halting && !remOvf;
    stb.consume = consumeStb && (inQueued != '0) && !halting && !stopped;
    stb.produce = produceStb && (inFlight != '0) && (outFull < outSize);
    stb.clear   = halting && (inFlight == '0);
  end

  // ring sizes and configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSize    <= '0;
      outSize   <= '0;
      cfgMask   <= 1'b0;
      cfgCoalEn <= 1'b0;
      cfgSoe    <= 1'b0;
      cntThr    <= '0;
      timThr    <= '0;
    end else begin
      if (regWe && regAddr == ADR_IN_SIZE)  inSize  <= regWdata[SIZE_W-1:0];
      if (regWe && regAddr == ADR_OUT_SIZE) outSize <= regWdata[SIZE_W-1:0];
      if (wrCfg) begin
        cfgMask   <= regWdata[0];
        cfgCoalEn <= regWdata[1];
        cfgSoe    <= regWdata[2];
        cntThr    <= regWdata[8 +: THR_W];
        timThr    <= regWdata[16 +: THR_W];
      end
    end
  end

  // interrupt status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag  <= 1'b0;
      errFlag   <= 1'b0;
      errType   <= '0;
      errIdx    <= '0;
      haltState <= HALT_IDLE;
    end else begin
      if (doneEvt)                    doneFlag <= 1'b1;
      else if (wrStat && regWdata[0]) doneFlag <= 1'b0;

      if (addOvf) begin
        errFlag <= 1'b1;
        errType <= ERR_ADD_OVF;
        errIdx  <= ERR_IDX_W'(inRdIdx);
      end else if (remOvf) begin
        errFlag <= 1'b1;
        errType <= ERR_REMOVE_OVF;
        errIdx  <= ERR_IDX_W'(outWrIdx);
      end else if (wrStat && regWdata[1]) begin
        errFlag <= 1'b0;
        errType <= '0;
        errIdx  <= '0;
      end

      if (wrCmd && regWdata[0] && !halting)                        haltState <= HALT_BUSY;
      else if (stb.clear)                                          haltState <= HALT_DONE;
      else if (wrStat && regWdata[3] && haltState == HALT_DONE)    haltState <= HALT_IDLE;
    end
  end

  assign irqOut = (doneFlag || errFlag) && !cfgMask;

  always_comb begin
    case (regAddr)
      ADR_IN_SIZE:  regRdata = 32'(inSize);
      ADR_OUT_SIZE: regRdata = 32'(outSize);
      ADR_ADD:      regRdata = 32'(room);
      ADR_REMOVE:   regRdata = 32'(outFull);
      ADR_CONFIG:   regRdata = (32'(timThr) << 16) | (32'(cntThr) << 8) |
                               32'({cfgSoe, cfgCoalEn, cfgMask});
      ADR_STATUS:   regRdata = {2'b00, errIdx, 4'h0, errType, 4'h0,
                                haltState, errFlag, doneFlag};
      ADR_INDEX:    regRdata = (32'(outWrIdx) << 16) | 32'(inRdIdx);
      default:      regRdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/jobring_occ_ctrl.sv
module jobring_occ_ctrl
  import jrq_pkg::*;
#(
  parameter int SIZE_W = 10,
  parameter int THR_W  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        consumeStb,
  input  logic        produceStb,
  output logic        irqOut
);
  ringStb_t          stb;
  logic [SIZE_W-1:0] cnt, inSize, outSize, room;
  logic [SIZE_W-1:0] inQueued, outFull, inRdIdx, outWrIdx;
  logic [SIZE_W:0]   inFlight;
  logic              cfgMask, cfgCoalEn, cfgSoe;
  logic [THR_W-1:0]  cntThr, timThr;
  logic [1:0]        haltState;
  logic              errFlag, doneFlag, doneEvt;
  logic [3:0]        errType;

  jrq_ctrl #(.SIZE_W(SIZE_W), .THR_W(THR_W)) u_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .consumeStb, .produceStb,
    .inQueued, .outFull, .inFlight, .inRdIdx, .outWrIdx, .doneEvt,
    .stb, .cnt, .inSize, .outSize, .room, .cfgMask, .cfgCoalEn, .cfgSoe,
    .cntThr, .timThr, .haltState, .errFlag, .errType, .doneFlag,
    .irqOut, .regRdata
  );

  jrq_counters #(.SIZE_W(SIZE_W)) u_counters (
    .clk, .rstN, .stb, .cnt, .inSize, .outSize,
    .inQueued, .outFull, .inRdIdx, .outWrIdx, .inFlight
  );

  jrq_coalesce #(.THR_W(THR_W)) u_coalesce (
    .clk, .rstN, .clear(stb.clear), .coalEn(cfgCoalEn),
    .produceOk(stb.produce), .cntThr, .timThr, .doneEvt
  );
endmodule

// File: rtl/jobring_occ_ctrl_chk.sv
module jobring_occ_ctrl_chk #(
  parameter int SIZE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [2:0]        regAddr,
  input logic [31:0]       regWdata,
  input logic              produceStb,
  input logic              consumeStb,
  input logic [SIZE_W-1:0] room,
  input logic [SIZE_W-1:0] inSize,
  input logic [SIZE_W-1:0] outSize,
  input logic [SIZE_W-1:0] outFull,
  input logic [SIZE_W-1:0] inRdIdx,
  input logic [SIZE_W-1:0] outWrIdx,
  input logic [SIZE_W:0]   inFlight,
  input logic [1:0]        haltState,
  input logic              errFlag,
  input logic [3:0]        errType,
  input logic              doneFlag,
  input logic              cfgCoalEn,
  input logic              cfgSoe
);
  assert_add_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd2 && haltState != 2'b01 && regWdata[SIZE_W-1:0] > room)
    |=> (errFlag && errType == 4'd9));

  assert_rem_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd3 && haltState != 2'b01 && regWdata[SIZE_W-1:0] > outFull)
    |=> (errFlag && errType == 4'd8));

  assert_done_nocoal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (produceStb && !cfgCoalEn && inFlight != '0 && outFull < outSize) |=> doneFlag);

  assert_stop_on_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && cfgSoe && consumeStb && haltState != 2'b01) |=> $stable(inRdIdx));

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    (haltState == 2'b01) |=> (inRdIdx == $past(inRdIdx) || haltState == 2'b10));

  assert_halt_clean_R10: assert property (@(posedge clk) disable iff (!rstN)
    (haltState == 2'b10 && $past(haltState) == 2'b01)
    |-> (room == inSize && outFull == '0 && inRdIdx == '0 && outWrIdx == '0));
endmodule

bind jobring_occ_ctrl jobring_occ_ctrl_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .produceStb(produceStb), .consumeStb(consumeStb), .room(room), .inSize(inSize),
  .outSize(outSize), .outFull(outFull), .inRdIdx(inRdIdx), .outWrIdx(outWrIdx),
  .inFlight(inFlight), .haltState(haltState), .errFlag(errFlag), .errType(errType),
  .doneFlag(doneFlag), .cfgCoalEn(cfgCoalEn), .cfgSoe(cfgSoe)
);

// File: tb/jobring_occ_ctrl_bench.sv
module jobring_occ_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        consumeStb = 1'b0;
  logic        produceStb = 1'b0;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    int          addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbQueue[$];
  event  chk;

  always #2.5 clk = ~clk;

  jobring_occ_ctrl u_jobring_occ_ctrl (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata,
    .consumeStb, .produceStb, .irqOut
  );

  // monitor: pops expected items and compares them with the design
  initial begin
    forever begin
      @(chk);
      #0.1;
      while (sbQueue.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbQueue.pop_front();
        act = (it.addr == 8) ? {31'd0, irqOut} : regRdata;
        testsRun++;
        if (act !== it.exp) begin
          testsFailed++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectRd(input int addr, input logic [31:0] exp, input string tag);
    item_t it;
    if (addr < 8) regAddr = addr[2:0];
    it.addr = addr; it.exp = exp; it.tag = tag;
    sbQueue.push_back(it);
    ->chk;
    #0.2;
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regAddr = addr[2:0]; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulse(input bit doConsume, input bit doProduce);
    @(negedge clk);
    consumeStb = doConsume; produceStb = doProduce;
    @(negedge clk);
    consumeStb = 1'b0; produceStb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    idle(2);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    expectRd(5, 32'h0, "R1 status");
    expectRd(2, 32'h0, "R1 room");
    expectRd(4, 32'h0, "R1 config");
    expectRd(8, 32'h0, "R1 irq");

    // R2 sizes and room
    wr(0, 8); wr(1, 4);
    expectRd(2, 32'd8, "R2 room after size");
    expectRd(3, 32'd0, "R2 full after size");
    wr(2, 5);
    expectRd(2, 32'd3, "R2 room after add");

    // R4 add overflow
    wr(2, 4);
    expectRd(2, 32'd3, "R4 room unchanged");
    expectRd(5, 32'h0000_0902, "R4 status");
    expectRd(8, 32'h1, "R7 irq on error");
    wr(5, 32'h2);
    expectRd(5, 32'h0, "R9 error cleared");
    expectRd(8, 32'h0, "R7 irq low");

    // R3 consumes
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    expectRd(2, 32'd6, "R2 room after consume");
    expectRd(7, 32'd3, "R3 input index");

    // R6 produce without coalescing
    pulse(0, 1);
    expectRd(3, 32'd1, "R2 full after produce");
    expectRd(5, 32'h1, "R6 done set");
    wr(5, 32'h1);

    // R5 remove overflow
    wr(3, 2);
    expectRd(3, 32'd1, "R5 full unchanged");
    expectRd(5, 32'h0001_0802, "R5 status");
    wr(5, 32'h2);
    wr(3, 1);
    expectRd(3, 32'd0, "R2 full after remove");

    // R7 mask
    wr(4, 32'h1);
    pulse(0, 1);
    expectRd(5, 32'h1, "R7 done while masked");
    expectRd(8, 32'h0, "R7 irq masked");
    wr(5, 32'h1);

    // R11 count threshold 3
    wr(4, 32'h0000_0302);
    expectRd(4, 32'h0000_0302, "R11 config readback");
    pulse(1, 0); pulse(1, 0);
    pulse(0, 1); pulse(0, 1);
    expectRd(5, 32'h0, "R11 below threshold");
    pulse(0, 1);
    expectRd(5, 32'h1, "R11 threshold reached");
    expectRd(3, 32'd4, "R2 output ring full");
    wr(5, 32'h1);
    wr(3, 4);
    expectRd(3, 32'd0, "R2 full drained");

    // R12 timer 5 cycles
    wr(4, 32'h0005_0302);
    wr(2, 3);
    pulse(1, 0);
    pulse(0, 1);
    expectRd(5, 32'h0, "R12 timer pending");
    idle(6);
    expectRd(5, 32'h1, "R12 timer fired");
    expectRd(7, 32'h0002_0006, "R3 index wrap");
    wr(5, 32'h1);

    // R8 stop on error
    wr(4, 32'h4);
    wr(2, 7);
    expectRd(5, 32'h0006_0902, "R4 status with index");
    pulse(1, 0);
    expectRd(2, 32'd6, "R8 consume ignored");
    expectRd(7, 32'h0002_0006, "R8 index held");
    wr(5, 32'h2);
    pulse(1, 0);
    expectRd(2, 32'd7, "R8 consume after clear");

    // R10 ring reset with one job in flight; R11 zero threshold
    wr(4, 32'h2);
    wr(6, 32'h1);
    expectRd(5, 32'h4, "R10 halt in progress");
    pulse(1, 0);
    wr(2, 1);
    expectRd(2, 32'd7, "R10 room frozen");
    pulse(0, 1);
    expectRd(5, 32'h5, "R11 zero threshold done");
    idle(1);
    expectRd(5, 32'h9, "R10 halt complete");
    expectRd(2, 32'd8, "R10 room reset");
    expectRd(3, 32'd0, "R10 full reset");
    expectRd(7, 32'h0, "R10 indices reset");
    wr(5, 32'h9);
    expectRd(5, 32'h0, "R9 halt and done cleared");

    idle(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule